// File: doc/BRIEF.md
# Text Font Base Address Selector

In text mode the glyph bitmaps live in display memory plane 2, and a character's attribute byte chooses one of two font slots for it. This block takes a glyph row request (character code, row inside the glyph, attribute bit 3), the font-select configuration byte and the large-memory enable. It returns the 16-bit plane-2 byte address of that glyph row.

Each font slot carries a 3-bit bank code. The code's bits are scattered across the configuration byte so that older software keeps working. The eight codes map to 8 KB banks in an interleaved order, not an ascending one. Inside the chosen bank every character takes 32 bytes, one per row. The address is registered and shows up one cycle after the request, with a valid strobe.

Top module: `font_addr_sel`

## Requirements
- R1: While reset is asserted, and after it is released until the first request, `addr_vld` is 0 and `font_addr` is 0000h.
- R2: When `attr_b3` is 1, the bank code is {`map_sel[5]`, `map_sel[3]`, `map_sel[2]`}, with `map_sel[5]` as its most significant bit.
- R3: When `attr_b3` is 0, the bank code is {`map_sel[4]`, `map_sel[1]`, `map_sel[0]`}, with `map_sel[4]` as its most significant bit.
- R4: Bank codes 0, 1, 2 and 3 give base addresses 0000h, 4000h, 8000h and C000h. Codes 4, 5, 6 and 7 give 2000h, 6000h, A000h and E000h.
- R5: The address is the base plus `char_code`*32 plus `row`. The offset always stays inside the 8 KB bank, and `char_code`=255 with `row`=31 reaches base+1FFFh.
- R6: When `ext_mem` is 0, the base is 0000h whatever `map_sel` and `attr_b3` hold.
- R7: A request sampled at a rising edge while `req` is 1 drives `addr_vld` to 1 and `font_addr` to its address after that same edge.
- R8: A rising edge with `req` at 0 drives `addr_vld` to 0 and leaves `font_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Glyph row request |
| char_code | input | 8 | Character code |
| row | input | 5 | Row index inside the glyph, 0 to 31 |
| attr_b3 | input | 1 | Attribute bit 3; 1 picks slot A, 0 picks slot B |
| map_sel | input | 8 | Font-select configuration byte |
| ext_mem | input | 1 | Large-memory enable; font selection works only when 1 |
| font_addr | output | 16 | Plane-2 byte address of the glyph row |
| addr_vld | output | 1 | Address valid, one cycle after the request |

## Verification
The bench walks all eight bank codes through slot A and then through slot B. In each pass the other slot's field holds a different code, so a swap of the slots, or a swap of the high bit with a low bit, lands in the wrong bank. Runs with the large-memory enable at 0, using non-zero select fields, show whether the base is forced to zero. Corner characters (0 and 255 with rows 0 and 31) check that the offset fills the bank without carrying into the base. Gaps between requests check that the address holds and the strobe drops.

// File: rtl/font_addr_sel.sv
module font_addr_sel #(
  parameter int CHAR_W = 8,
  parameter int ROW_W  = 5,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [CHAR_W-1:0] char_code,
  input  logic [ROW_W-1:0]  row,
  input  logic              attr_b3,
  input  logic [7:0]        map_sel,
  input  logic              ext_mem,
  output logic [ADDR_W-1:0] font_addr,
  output logic              addr_vld
);
  localparam int OFS_W = CHAR_W + ROW_W;

  logic [2:0]        bank;
  logic [2:0]        bank_eff;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] nxt;

  assign bank     = attr_b3 ? {map_sel[5], map_sel[3:2]} : {map_sel[4], map_sel[1:0]};
  assign bank_eff = ext_mem ? bank : 3'b000;
  assign base     = {bank_eff[1:0], bank_eff[2], {(ADDR_W-3){1'b0}}};
  assign nxt      = base | {{(ADDR_W-OFS_W){1'b0}}, char_code, row};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      font_addr <= '0;
      addr_vld  <= 1'b0;
    end else begin
      addr_vld <= req;
      if (req) font_addr <= nxt;
    end
  end
endmodule

// File: rtl/font_addr_sel_chk.sv
module font_addr_sel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic [7:0]  char_code,
  input logic [4:0]  row,
  input logic        attr_b3,
  input logic [7:0]  map_sel,
  input logic        ext_mem,
  input logic [15:0] font_addr,
  input logic        addr_vld
);
  a_r7_strobe: assert property (@(posedge clk) disable iff (!rst_n) req |=> addr_vld);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> (!addr_vld && $stable(font_addr)));
  a_r5_offset: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> font_addr[12:0] == {$past(char_code), $past(row)});
  a_r6_no_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ext_mem) |=> font_addr[15:13] == 3'b000);
  a_r2_slot_a: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ext_mem && attr_b3) |=>
      font_addr[15:13] == {$past(map_sel[3]), $past(map_sel[2]), $past(map_sel[5])});
  a_r3_slot_b: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ext_mem && !attr_b3) |=>
      font_addr[15:13] == {$past(map_sel[1]), $past(map_sel[0]), $past(map_sel[4])});
endmodule

bind font_addr_sel font_addr_sel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .char_code(char_code), .row(row),
  .attr_b3(attr_b3), .map_sel(map_sel), .ext_mem(ext_mem),
  .font_addr(font_addr), .addr_vld(addr_vld)
);

// File: tb/font_addr_sel_test.sv
`timescale 1ns/1ps
module font_addr_sel_test;
  logic clk = 0, rst_n = 0, req = 0, attr = 0, ext = 0;
  logic [7:0] ch = 0, sel = 0;
  logic [4:0] row = 0;
  logic [15:0] addr;
  logic vld;
  int checks = 0, fails = 0;
  int exp_addr = 0;
  bit exp_vld = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  font_addr_sel uut (
    .clk(clk), .rst_n(rst_n), .req(req), .char_code(ch), .row(row),
    .attr_b3(attr), .map_sel(sel), .ext_mem(ext),
    .font_addr(addr), .addr_vld(vld)
  );

  task automatic compare();
    checks++;
    if (vld !== exp_vld) begin
      fails++;
      $display("FAIL %s addr_vld actual %0b expected %0b", exp_vld ? "R7" : "R8", vld, exp_vld);
    end
    checks++;
    if (addr !== exp_addr[15:0]) begin
      fails++;
      $display("FAIL %s font_addr actual %h expected %h", tag, addr, exp_addr[15:0]);
    end
  endtask

  task automatic step(input bit r, input int c, input int rw, input bit a,
                      input int s, input bit e, input string t);
    int hi, lo, base;
    @(negedge clk);
    compare();
    req = r; ch = c[7:0]; row = rw[4:0]; attr = a; sel = s[7:0]; ext = e;
    tag = t;
    if (r) begin
      hi = a ? (s >> 5) & 1 : (s >> 4) & 1;
      lo = a ? (s >> 2) & 3 : s & 3;
      base = e ? lo * 16384 + hi * 8192 : 0;
      exp_addr = base + c * 32 + rw;
      exp_vld = 1;
    end else begin
      exp_vld = 0;
    end
  endtask

  function automatic int pack_a(int code, int other);
    return ((code >> 2) << 5) | ((code & 3) << 2) | ((other >> 2) << 4) | (other & 3);
  endfunction

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); compare();
    @(negedge clk); compare();
    rst_n = 1;
    step(0, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 0, "R1");
    for (int k = 0; k < 8; k++)
      step(1, 16 + k, k, 1, pack_a(k, 7 - k), 1, "R2_R4");
    for (int k = 0; k < 8; k++)
      step(1, 40 + k, 31 - k, 0, pack_a(7 - k, k), 1, "R3_R4");
    step(1, 200, 9, 1, 8'h3F, 0, "R6");
    step(1, 201, 3, 0, 8'h3F, 0, "R6");
    step(1, 255, 31, 1, pack_a(0, 5), 1, "R5");
    step(1, 255, 31, 0, pack_a(2, 7), 1, "R5");
    step(1, 0, 0, 1, pack_a(7, 0), 1, "R5");
    step(0, 99, 7, 0, 8'hFF, 1, "R8");
    step(0, 12, 1, 1, 8'h00, 0, "R8");
    step(1, 65, 14, 1, 8'h24, 1, "R7");
    step(0, 0, 0, 0, 0, 0, "R8");
    step(1, 66, 15, 0, 8'h13, 1, "R7");
    step(1, 67, 16, 1, 8'h13, 1, "R7");
    step(0, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 0, "R8");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule